// File: doc/BRIEF.md
# Interval Timer with Free-Running User Counter

This block is a memory-mapped timer with a 32-bit register interface. It decodes word-aligned offsets inside a 32-byte window and uses a single-cycle read strobe and a single-cycle write strobe. A tick-enable input marks each 500 ns count period. The count advances by one on every clock cycle in which that input is high.

In system mode the block is an interval timer. The count climbs from zero toward a programmed limit. When it reaches the limit it wraps to zero, sets a sticky reached flag and raises a level interrupt. Software reads the limit register to acknowledge the interrupt. That read also clears the flag and starts a new interval. A mode bit switches the same counter to user mode. There it counts freely past the limit and can be paused and resumed by software. Its wide value is read as a low part and a high part, and the interrupt output stays low.

Top module: `lct_timer`

## Requirements
- R1: In system mode, a read of offset 0x04 shows the count in bits 30..9. Bits 8..0 are always zero. The count goes up by one unit of bit 9 on every clock edge where tick_en is high.
- R2: In system mode, let U be the effective limit's bits 30..9, with U taken as 1 when those bits are 0. A tick that finds the count at U-1 or above sets the count to 0, sets the reached flag and asserts irq_o. All three changes appear at the same edge. The reached flag reads as bit 31 of offset 0x04.
- R3: A limit write of value 0 stores 0x7FFFFFFF. Any other value is stored with bit 31 cleared. In system mode the stored limit reads back at offset 0x00. A stored limit of 0 (the reset value) counts as 0x7FFFFFFF.
- R4: A limit write at offset 0x00 restarts the count from zero and deasserts irq_o, but does not clear the reached flag. A limit write at offset 0x08 leaves the count and irq_o untouched.
- R5: In system mode, a read of offset 0x00 deasserts irq_o, clears the reached flag and restarts the count from zero. A tick in the same cycle is ignored.
- R6: Bit 0 of a write to offset 0x10 selects user mode (1) or system mode (0). A read of offset 0x10 returns that bit in bit 0.
- R7: In user mode the count does not wrap at the limit and irq_o is held low. Offset 0x04 reads {0, count[21:0], nine zero bits}. Offset 0x00 reads count bits 52..22 in bits 30..0, and that read has no side effects.
- R8: In user mode, writing 1 to bit 0 of offset 0x0C stops the count and writing 0 resumes it with its value kept. Writes to 0x0C are ignored in system mode. A read of offset 0x0C returns the stopped status in bit 0 in either mode.
- R9: After reset the limit reads 0, the count is 0, the reached flag is clear, the counter is stopped, the mode is system, irq_o is low and rdata_o is 0.
- R10: Reads of offsets 0x08, 0x14, 0x18 and 0x1C return 0. Writes to 0x14, 0x18 and 0x1C change nothing.
- R11: rdata_o is registered. It shows the selected value on the clock after rd_en and holds it until the next read. The value reflects the state before that read's own side effects and before any change made at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick, one count per high cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 5 | Byte offset within the window |
| wdata | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt, system mode only |

## Verification
Every state change, whether from a tick, a write or the side effect of a read, takes effect at the edge where its strobe is high. Read data for an access is due one cycle after rd_en, and irq_o and the reached flag become visible one cycle after the tick that wraps the count. The bench changes inputs on the falling edge, so each strobe or tick covers exactly one rising edge. It then samples rdata_o and irq_o at the next falling edge. That is the first moment the result is due and well before it could change again. Same-edge cases are driven in a single cycle: a tick together with a limit read, and a tick together with a count read at the wrap.

// File: rtl/lct_pkg.sv
`timescale 1ns/1ps
package lct_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int FRAC_W = 9;
    localparam int LIM_W  = DATA_W - 1;

    // register selected by the word index of the offset
    typedef enum logic [2:0] {
        SEL_LIMIT = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_LIMNR = 3'd2,
        SEL_RUN   = 3'd3,
        SEL_MODE  = 3'd4,
        SEL_NONE  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/lct_decode.sv
`timescale 1ns/1ps
module lct_decode
    import lct_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr[ADDR_W-1:2])
            3'd0:    sel = SEL_LIMIT;
            3'd1:    sel = SEL_COUNT;
            3'd2:    sel = SEL_LIMNR;
            3'd3:    sel = SEL_RUN;
            3'd4:    sel = SEL_MODE;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/lct_count_next.sv
`timescale 1ns/1ps
module lct_count_next
    import lct_pkg::*;
#(
    parameter int CNT_W = 53,
    parameter int LO_W  = 22
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [LIM_W-1:0] limit_q,
    input  logic             user_mode,
    input  logic             stopped,
    input  logic             tick,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt_d,
    output logic             wrap
);
    localparam int UNIT_W = LIM_W - FRAC_W;

    logic [LIM_W-1:0]  eff_limit;
    logic [UNIT_W-1:0] units;
    logic [UNIT_W-1:0] last_unit;
    logic              advance;

    always_comb begin
        eff_limit = (limit_q == '0) ? '1 : limit_q;
        units     = eff_limit[LIM_W-1:FRAC_W];
        if (units == '0) begin
            units = UNIT_W'(1);
        end
        last_unit = units - UNIT_W'(1);
        advance   = tick && !(user_mode && stopped) && !restart;
        wrap      = advance && !user_mode && (cnt_q >= CNT_W'(last_unit));
        if (restart || wrap) begin
            cnt_d = '0;
        end else if (advance) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end
endmodule

// File: rtl/lct_read_mux.sv
`timescale 1ns/1ps
module lct_read_mux
    import lct_pkg::*;
#(
    parameter int CNT_W = 53,
    parameter int LO_W  = 22
) (
    input  reg_sel_e          sel,
    input  logic              user_mode,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [LIM_W-1:0]  limit_q,
    input  logic              reached,
    input  logic              stopped,
    output logic [DATA_W-1:0] rd_value
);
    logic [DATA_W-1:0] hi_part;
    logic [DATA_W-1:0] lo_part;

    always_comb begin
        hi_part = DATA_W'(cnt_q[CNT_W-1:LO_W]);
        hi_part[DATA_W-1] = 1'b0;
        lo_part = {1'b0, cnt_q[LO_W-1:0], {FRAC_W{1'b0}}};
        unique case (sel)
            SEL_LIMIT: rd_value = user_mode ? hi_part : {1'b0, limit_q};
            SEL_COUNT: rd_value = user_mode ? lo_part
                                            : {reached, lo_part[DATA_W-2:0]};
            SEL_RUN:   rd_value = {{(DATA_W-1){1'b0}}, stopped};
            SEL_MODE:  rd_value = {{(DATA_W-1){1'b0}}, user_mode};
            default:   rd_value = '0;
        endcase
    end
endmodule

// File: rtl/lct_timer.sv
`timescale 1ns/1ps
module lct_timer
    import lct_pkg::*;
#(
    parameter int CNT_LO_W = 22,
    parameter int CNT_HI_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int CNT_W = CNT_LO_W + CNT_HI_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LIM_W-1:0]  limit;
        logic              reached;
        logic              irq;
        logic              stopped;
        logic              user;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t            st_d, st_q;
    reg_sel_e          sel;
    logic              restart;
    logic              wrap;
    logic [CNT_W-1:0]  cnt_next;
    logic [DATA_W-1:0] rd_value;
    logic [LIM_W-1:0]  lim_val;

    lct_decode u_decode (
        .addr (addr),
        .sel  (sel)
    );

    lct_count_next #(.CNT_W(CNT_W), .LO_W(CNT_LO_W)) u_count (
        .cnt_q     (st_q.cnt),
        .limit_q   (st_q.limit),
        .user_mode (st_q.user),
        .stopped   (st_q.stopped),
        .tick      (tick_en),
        .restart   (restart),
        .cnt_d     (cnt_next),
        .wrap      (wrap)
    );

    lct_read_mux #(.CNT_W(CNT_W), .LO_W(CNT_LO_W)) u_rmux (
        .sel       (sel),
        .user_mode (st_q.user),
        .cnt_q     (st_q.cnt),
        .limit_q   (st_q.limit),
        .reached   (st_q.reached),
        .stopped   (st_q.stopped),
        .rd_value  (rd_value)
    );

    always_comb begin
        lim_val = (wdata == '0) ? '1 : wdata[LIM_W-1:0];
        restart = (wr_en && sel == SEL_LIMIT) ||
                  (rd_en && sel == SEL_LIMIT && !st_q.user);
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_next;
        if (wrap) begin
            st_d.reached = 1'b1;
            st_d.irq     = 1'b1;
        end
        if (wr_en) begin
            unique case (sel)
                SEL_LIMIT: begin
                    st_d.limit = lim_val;
                    st_d.irq   = 1'b0;
                end
                SEL_LIMNR: st_d.limit = lim_val;
                SEL_RUN:   if (st_q.user) st_d.stopped = wdata[0];
                SEL_MODE:  st_d.user = wdata[0];
                default:   ;
            endcase
        end
        if (rd_en) begin
            st_d.rdata = rd_value;
            if (sel == SEL_LIMIT && !st_q.user) begin
                st_d.irq     = 1'b0;
                st_d.reached = 1'b0;
            end
        end
        if (st_d.user) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.stopped <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;
    assign irq_o   = st_q.irq;

    // R7
    user_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.user |-> !irq_o);

    // R5
    rd_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_LIMIT && !st_q.user) |=> (!irq_o && !st_q.reached));

    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.user && st_q.stopped && !wr_en) |=> $stable(st_q.cnt));

    // R2
    reach_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.reached) |-> $past(tick_en));

    // R1
    frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_COUNT) |=> (rdata_o[FRAC_W-1:0] == '0));
endmodule

// File: tb/lct_timer_tb.sv
`timescale 1ns/1ps
module lct_timer_tb;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 55;
    localparam vec_t VEC [NV] = '{
        '{OP_RD,  5'h00, 32'h0,          32'h0,          4'd9},  // R9 limit
        '{OP_RD,  5'h0C, 32'h0,          32'h1,          4'd9},  // R9 stopped
        '{OP_RD,  5'h10, 32'h0,          32'h0,          4'd9},  // R9 mode
        '{OP_RD,  5'h04, 32'h0,          32'h0,          4'd9},  // R9 count
        '{OP_WR,  5'h00, 32'h0000_0A00,  32'h0,          4'd3},
        '{OP_TK,  5'h00, 32'd3,          32'h0,          4'd1},
        '{OP_RD,  5'h04, 32'h0,          32'h0000_0600,  4'd1},  // R1
        '{OP_TK,  5'h00, 32'd2,          32'h0,          4'd2},
        '{OP_RD,  5'h04, 32'h0,          32'h8000_0000,  4'd2},  // R2
        '{OP_IRQ, 5'h00, 32'h0,          32'h1,          4'd2},  // R2
        '{OP_RD,  5'h00, 32'h0,          32'h0000_0A00,  4'd5},  // R5
        '{OP_IRQ, 5'h00, 32'h0,          32'h0,          4'd5},
        '{OP_RD,  5'h04, 32'h0,          32'h0,          4'd5},
        '{OP_WR,  5'h00, 32'h0,          32'h0,          4'd3},
        '{OP_RD,  5'h00, 32'h0,          32'h7FFF_FFFF,  4'd3},  // R3
        '{OP_WR,  5'h00, 32'h8000_1200,  32'h0,          4'd3},
        '{OP_RD,  5'h00, 32'h0,          32'h0000_1200,  4'd3},
        '{OP_TK,  5'h00, 32'd4,          32'h0,          4'd4},
        '{OP_WR,  5'h08, 32'h0000_1400,  32'h0,          4'd4},
        '{OP_RD,  5'h04, 32'h0,          32'h0000_0800,  4'd4},  // R4
        '{OP_WR,  5'h14, 32'hFFFF_FFFF,  32'h0,          4'd10},
        '{OP_RD,  5'h14, 32'h0,          32'h0,          4'd10}, // R10
        '{OP_RD,  5'h08, 32'h0,          32'h0,          4'd10},
        '{OP_RD,  5'h04, 32'h0,          32'h0000_0800,  4'd10},
        '{OP_RD,  5'h00, 32'h0,          32'h0000_1400,  4'd4},
        '{OP_WR,  5'h0C, 32'h0,          32'h0,          4'd8},
        '{OP_RD,  5'h0C, 32'h0,          32'h1,          4'd8},  // R8 ignored
        '{OP_WR,  5'h10, 32'h1,          32'h0,          4'd6},
        '{OP_RD,  5'h10, 32'h0,          32'h1,          4'd6},  // R6
        '{OP_WR,  5'h00, 32'h0000_0A00,  32'h0,          4'd4},
        '{OP_TK,  5'h00, 32'd7,          32'h0,          4'd8},
        '{OP_RD,  5'h04, 32'h0,          32'h0,          4'd8},  // R8 stopped
        '{OP_WR,  5'h0C, 32'h0,          32'h0,          4'd8},
        '{OP_RD,  5'h0C, 32'h0,          32'h0,          4'd8},
        '{OP_TK,  5'h00, 32'd7,          32'h0,          4'd7},
        '{OP_RD,  5'h04, 32'h0,          32'h0000_0E00,  4'd7},  // R7 no wrap
        '{OP_IRQ, 5'h00, 32'h0,          32'h0,          4'd7},
        '{OP_RD,  5'h00, 32'h0,          32'h0,          4'd7},
        '{OP_RD,  5'h04, 32'h0,          32'h0000_0E00,  4'd7},
        '{OP_WR,  5'h0C, 32'h1,          32'h0,          4'd8},
        '{OP_TK,  5'h00, 32'd3,          32'h0,          4'd8},
        '{OP_RD,  5'h04, 32'h0,          32'h0000_0E00,  4'd8},
        '{OP_RD,  5'h0C, 32'h0,          32'h1,          4'd8},
        '{OP_WR,  5'h0C, 32'h0,          32'h0,          4'd8},
        '{OP_TK,  5'h00, 32'd1,          32'h0,          4'd8},
        '{OP_RD,  5'h04, 32'h0,          32'h0000_1000,  4'd8},  // R8 resume
        '{OP_WR,  5'h10, 32'h0,          32'h0,          4'd6},
        '{OP_RD,  5'h10, 32'h0,          32'h0,          4'd6},
        '{OP_TK,  5'h00, 32'd1,          32'h0,          4'd2},
        '{OP_RD,  5'h04, 32'h0,          32'h8000_0000,  4'd2},  // R2 above limit
        '{OP_IRQ, 5'h00, 32'h0,          32'h1,          4'd2},
        '{OP_WR,  5'h00, 32'h0000_0A00,  32'h0,          4'd4},
        '{OP_IRQ, 5'h00, 32'h0,          32'h0,          4'd4},  // R4 write clears
        '{OP_RD,  5'h04, 32'h0,          32'h8000_0000,  4'd4},  // R4 reached kept
        '{OP_RD,  5'h00, 32'h0,          32'h0000_0A00,  4'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_o;
    logic        irq_o;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #10 clk = ~clk;

    lct_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata_o (rdata_o),
        .irq_o   (irq_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata_o;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        check("R9 rdata after reset", rdata_o, 32'h0);
        check("R9 irq after reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VEC[i].req, i);
            case (VEC[i].op)
                OP_WR:  bus_wr(VEC[i].addr, VEC[i].data);
                OP_RD:  begin
                    bus_rd(VEC[i].addr, rd);
                    check(tag, rd, VEC[i].exp);
                end
                OP_TK:  ticks(int'(VEC[i].data));
                default: check(tag, {31'b0, irq_o}, VEC[i].exp);
            endcase
        end

        // R2: limit below one count unit behaves as one unit
        bus_wr(5'h00, 32'h0000_0100);
        ticks(1);
        bus_rd(5'h04, rd);
        check("R2 sub-unit limit reached", rd, 32'h8000_0000);
        check("R2 sub-unit limit irq", {31'b0, irq_o}, 32'h1);
        bus_rd(5'h00, rd);
        check("R3 sub-unit limit readback", rd, 32'h0000_0100);

        // R5: tick in the same cycle as the acknowledge read is dropped
        bus_wr(5'h00, 32'h0000_0A00);
        ticks(2);
        tick_en = 1'b1;
        bus_rd(5'h00, rd);
        tick_en = 1'b0;
        check("R5 ack read value", rd, 32'h0000_0A00);
        bus_rd(5'h04, rd);
        check("R5 tick ignored at restart", rd, 32'h0);

        // R11: read at the wrapping edge returns the pre-edge count
        ticks(4);
        tick_en = 1'b1;
        bus_rd(5'h04, rd);
        tick_en = 1'b0;
        check("R11 pre-edge count", rd, 32'h0000_0800);
        repeat (3) @(negedge clk);
        check("R11 rdata held", rdata_o, 32'h0000_0800);
        bus_rd(5'h04, rd);
        check("R11 wrap seen next read", rd, 32'h8000_0000);

        // R7: entering user mode drops a pending interrupt
        check("R7 irq before mode change", {31'b0, irq_o}, 32'h1);
        bus_wr(5'h10, 32'h1);
        check("R7 irq after mode change", {31'b0, irq_o}, 32'h0);

        // R9: reset in the middle of a running user count
        bus_wr(5'h0C, 32'h0);
        ticks(3);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R9 rdata after mid reset", rdata_o, 32'h0);
        bus_rd(5'h10, rd);
        check("R9 mode after mid reset", rd, 32'h0);
        bus_rd(5'h0C, rd);
        check("R9 stopped after mid reset", rd, 32'h1);
        bus_rd(5'h04, rd);
        check("R9 count after mid reset", rd, 32'h0);
        bus_rd(5'h00, rd);
        check("R9 limit after mid reset", rd, 32'h0);
        check("R9 irq after mid reset", {31'b0, irq_o}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule